// File: doc/BRIEF.md
# Iterative Decimal (BCD) Multiplier

This block multiplies two unsigned packed-BCD integers of `N` digits each and returns the full `2N`-digit BCD product. It works one multiplier digit per cycle, least significant digit first. In each step a row of `N` single-digit decimal multipliers scales the whole multiplicand by the current multiplier digit, giving a partial product of `N+1` digits. A decimal accumulator then adds that partial product and shifts right by one digit. Each digit that leaves the accumulator is a finished low digit of the product.

Partial-product generation and accumulation sit in two pipeline stages. The last accumulation of one operation therefore runs in the same cycle as the first partial-product step of the next one. A caller presents operands with `in_valid` and they are taken on a clock edge where `ready` is high. The product appears `N+1` cycles later, marked by a one-cycle `done` pulse. With operands offered continuously, a new pair is taken every `N` cycles.

Top module: `bcd_iter_mul`

## Requirements
- R1: For operands whose 4-bit fields each hold a value 0 to 9 (digit i in bits 4i+3..4i, digit 0 least significant), `product` equals the decimal product of `mcand` and `mplier` in the same digit packing.
- R2: `done` is high for exactly one cycle per operation. `product` is valid in that cycle and holds its value until the next `done`.
- R3: An operation taken on clock edge t raises `done` (with its product) right after edge t+N+1, and `done` stays low after edges t+1 to t+N.
- R4: `ready` goes high again right after edge t+N-1. A pair taken on edge t+N completes correctly right after edge t+2N+1, with no stall between the two operations.
- R5: While `ready` is low, `in_valid` and the operand inputs have no effect: no extra operation starts and no result changes.
- R6: A synchronous active-high `rst` drives `ready` to 1, `done` to 0 and `product` to all zeros.
- R7: Timing does not depend on the data. Zero operands and zero multiplier digits each still take one step, so latency stays N+1.
- R8: The largest operands (all digits 9) give the correct product, with decimal carries rippling across every digit position, e.g. 99999999 x 99999999 = 9999999800000001 for N=8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered this cycle |
| ready | output | 1 | Operand pair will be taken at the next edge if in_valid is high |
| mcand | input | 4*N | Multiplicand, packed BCD |
| mplier | input | 4*N | Multiplier, packed BCD, consumed lowest digit first |
| product | output | 8*N | Product, packed BCD, registered |
| done | output | 1 | One-cycle pulse, product valid |

## Verification
An operand pair is taken on edge t, so its `done` pulse and product are due after edge t+N+1, and `ready` is due to return after edge t+N-1. The bench drives inputs and samples outputs on falling edges. It counts rising edges from the acceptance edge and checks `done` low on every edge up to t+N and high exactly at t+N+1. In the back-to-back case it offers the second pair at the moment `ready` returns. It then expects the first result at t+N+1, `done` low and the product held in between, and the second result at t+2N+1. Reference products come from converting the BCD operands to integers, multiplying, and converting back.

// File: rtl/bcd_mul_pkg.sv
package bcd_mul_pkg;
  localparam int DIG_W = 4;
  typedef logic [DIG_W-1:0] digit_t;
endpackage

// File: rtl/bcd_digit_mul.sv
module bcd_digit_mul
  import bcd_mul_pkg::*;
(
  input  digit_t a,
  input  digit_t b,
  output digit_t tens,
  output digit_t units
);
  logic [6:0] p;
  assign p     = {3'b000, a} * {3'b000, b};
  assign tens  = DIG_W'(p / 7'd10);
  assign units = DIG_W'(p % 7'd10);
endmodule

// File: rtl/bcd_add.sv
module bcd_add
  import bcd_mul_pkg::*;
#(
  parameter int DIG = 9
) (
  input  logic [DIG*DIG_W-1:0] a,
  input  logic [DIG*DIG_W-1:0] b,
  output logic [DIG*DIG_W-1:0] sum,
  output logic                 cout
);
  logic [DIG:0] c;
  assign c[0] = 1'b0;

  for (genvar g = 0; g < DIG; g++) begin : g_dig
    logic [4:0] raw;
    assign raw      = {1'b0, a[g*DIG_W +: DIG_W]} + {1'b0, b[g*DIG_W +: DIG_W]} + {4'b0000, c[g]};
    assign c[g+1]   = (raw > 5'd9);
    // digit sums above nine get the +6 correction; bit 4 is the decimal carry
    assign sum[g*DIG_W +: DIG_W] = c[g+1] ? DIG_W'(raw + 5'd6) : raw[3:0];
  end

  assign cout = c[DIG];
endmodule

// File: rtl/bcd_pp_row.sv
module bcd_pp_row
  import bcd_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N*DIG_W-1:0]     a,
  input  digit_t                 d,
  output logic [(N+1)*DIG_W-1:0] pp,
  output logic                   cout
);
  logic [N*DIG_W-1:0] units_v;
  logic [N*DIG_W-1:0] tens_v;

  for (genvar g = 0; g < N; g++) begin : g_mul
    bcd_digit_mul u_dm (
      .a    (a[g*DIG_W +: DIG_W]),
      .b    (d),
      .tens (tens_v[g*DIG_W +: DIG_W]),
      .units(units_v[g*DIG_W +: DIG_W])
    );
  end

  // tens digits sit one position above their units digits
  bcd_add #(.DIG(N+1)) u_add (
    .a   ({{DIG_W{1'b0}}, units_v}),
    .b   ({tens_v, {DIG_W{1'b0}}}),
    .sum (pp),
    .cout(cout)
  );
endmodule

// File: rtl/bcd_iter_mul.sv
module bcd_iter_mul
  import bcd_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               ready,
  input  logic [4*N-1:0]     mcand,
  input  logic [4*N-1:0]     mplier,
  output logic [8*N-1:0]     product,
  output logic               done
);
  localparam int OPW = N * DIG_W;
  localparam int PPW = (N + 1) * DIG_W;
  localparam int LOW = (N - 1) * DIG_W;
  localparam int CW  = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  // stage 1: operand hold and partial product generation
  logic [OPW-1:0] a_reg;
  logic [OPW-1:0] b_sh;
  logic [CW-1:0]  cnt;
  logic           active;
  logic           accept;
  logic [PPW-1:0] pp_comb;
  logic           row_cout;

  logic [PPW-1:0] pp_q;
  logic           pp_valid, pp_first, pp_last;

  // stage 2: accumulator
  logic [OPW-1:0] acc_hi;
  logic [LOW-1:0] lo;
  logic [PPW-1:0] acc_sum;
  logic           acc_cout;
  logic [PPW-1:0] acc_base;

  assign accept = in_valid && ready;

  bcd_pp_row #(.N(N)) u_row (
    .a   (a_reg),
    .d   (b_sh[DIG_W-1:0]),
    .pp  (pp_comb),
    .cout(row_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_reg  <= '0;
      b_sh   <= '0;
      cnt    <= '0;
      active <= 1'b0;
      ready  <= 1'b1;
    end else if (accept) begin
      a_reg  <= mcand;
      b_sh   <= mplier;
      cnt    <= '0;
      active <= 1'b1;
      ready  <= (N == 1);
    end else if (active) begin
      b_sh <= b_sh >> DIG_W;
      if (cnt == LAST) begin
        cnt    <= '0;
        active <= 1'b0;
        ready  <= 1'b1;
      end else begin
        cnt   <= cnt + 1'b1;
        ready <= ((cnt + 1'b1) == LAST);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_q     <= '0;
      pp_valid <= 1'b0;
      pp_first <= 1'b0;
      pp_last  <= 1'b0;
    end else begin
      pp_q     <= pp_comb;
      pp_valid <= active;
      pp_first <= active && (cnt == '0);
      pp_last  <= active && (cnt == LAST);
    end
  end

  assign acc_base = pp_first ? '0 : {{DIG_W{1'b0}}, acc_hi};

  bcd_add #(.DIG(N+1)) u_acc (
    .a   (acc_base),
    .b   (pp_q),
    .sum (acc_sum),
    .cout(acc_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hi  <= '0;
      lo      <= '0;
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (pp_valid) begin
        acc_hi <= acc_sum[PPW-1:DIG_W];
        lo     <= {acc_sum[DIG_W-1:0], lo[LOW-1:DIG_W]};
        if (pp_last) begin
          product <= {acc_sum[PPW-1:DIG_W], acc_sum[DIG_W-1:0], lo};
          done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bcd_iter_mul_chk.sv
module bcd_iter_mul_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           ready,
  input logic           done,
  input logic [8*N-1:0] product,
  input logic           row_cout,
  input logic           acc_cout,
  input logic           pp_valid
);
  logic [N+1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[N:0], in_valid && ready};
  end

  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));

  // R3: done exactly N+1 edges after acceptance (window tracked by hist)
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    done == hist[N+1]);

  p_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ready) |=> !ready);

  p_reset_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ready && !done && product == '0));

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    !row_cout && !(pp_valid && acc_cout));
endmodule

bind bcd_iter_mul bcd_iter_mul_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .ready   (ready),
  .done    (done),
  .product (product),
  .row_cout(row_cout),
  .acc_cout(acc_cout),
  .pp_valid(pp_valid)
);

// File: tb/bcd_iter_mul_bench.sv
`timescale 1ns/1ps
module bcd_iter_mul_bench;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           ready;
  logic [4*N-1:0] mcand = '0;
  logic [4*N-1:0] mplier = '0;
  logic [8*N-1:0] product;
  logic           done;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bcd_iter_mul #(.N(N)) u_bcd_iter_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ready(ready),
    .mcand(mcand), .mplier(mplier), .product(product), .done(done)
  );

  function automatic longint unsigned from_bcd(input logic [8*N-1:0] v);
    longint unsigned r = 0;
    for (int i = 2*N-1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [8*N-1:0] to_bcd(input longint unsigned v);
    logic [8*N-1:0] r = '0;
    longint unsigned t = v;
    for (int i = 0; i < 2*N; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [8*N-1:0] ref_mul(input logic [4*N-1:0] a, input logic [4*N-1:0] b);
    return to_bcd(from_bcd({{(4*N){1'b0}}, a}) * from_bcd({{(4*N){1'b0}}, b}));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  // one operation; optional junk offered while ready is low (R5)
  task automatic t_single(input logic [4*N-1:0] a, input logic [4*N-1:0] b,
                          input string req, input bit junk);
    logic [8*N-1:0] exp = ref_mul(a, b);
    int first_done = -1;
    logic [8*N-1:0] held;
    wait_ready();
    in_valid = 1'b1; mcand = a; mplier = b;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    if (junk) begin
      in_valid = 1'b1; mcand = 32'h99999999; mplier = 32'h11111111;
      chk("R5 ready low while busy", 64'(ready), 64'd0);
    end
    for (int k = 1; k <= N + 1; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == N - 2) in_valid = 1'b0;
      if (done && first_done < 0) first_done = k;
    end
    chk({req, " latency N+1"}, 64'(first_done), 64'(N + 1));
    chk({req, " product"}, product, exp);
    held = product;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done) first_done = -2;
    end
    chk({req, " R2 no extra done, R5 junk ignored"}, 64'(first_done), 64'(N + 1));
    chk({req, " R2 product held"}, product, held);
  endtask

  task automatic t_back_to_back(input logic [4*N-1:0] a1, input logic [4*N-1:0] b1,
                                input logic [4*N-1:0] a2, input logic [4*N-1:0] b2);
    logic [8*N-1:0] e1 = ref_mul(a1, b1);
    logic [8*N-1:0] e2 = ref_mul(a2, b2);
    int dcount = 0;
    bit held_ok = 1'b1;
    wait_ready();
    in_valid = 1'b1; mcand = a1; mplier = b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    for (int k = 1; k <= 2*N + 1; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == N - 1) begin
        chk("R4 ready back after N-1 edges", 64'(ready), 64'd1);
        in_valid = 1'b1; mcand = a2; mplier = b2;
      end
      if (k == N) begin
        in_valid = 1'b0;
        chk("R4 ready low after second accept", 64'(ready), 64'd0);
      end
      if (done) dcount++;
      if (k == N + 1) begin
        chk("R4 first done at N+1", 64'(done), 64'd1);
        chk("R4 first product", product, e1);
      end
      if (k == N + 2) chk("R2 done one cycle", 64'(done), 64'd0);
      if (k > N + 1 && k <= 2*N && product !== e1) held_ok = 1'b0;
      if (k == 2*N + 1) begin
        chk("R4 second done at 2N+1", 64'(done), 64'd1);
        chk("R4 second product", product, e2);
      end
    end
    chk("R2 product held between pulses", 64'(held_ok), 64'd1);
    chk("R2 exactly two done pulses", 64'(dcount), 64'd2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 reset ready", 64'(ready), 64'd1);
    chk("R6 reset done", 64'(done), 64'd0);
    chk("R6 reset product", product, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 idle ready", 64'(ready), 64'd1);

    t_single(32'h12345678, 32'h87654321, "R1 R3 mixed", 1'b0);
    t_single(32'h00000007, 32'h00000006, "R1 small", 1'b0);
    t_single(32'h00000000, 32'h99999999, "R7 zero mcand", 1'b0);
    t_single(32'h12345678, 32'h00000000, "R7 zero mplier", 1'b0);
    t_single(32'h56789012, 32'h10203040, "R7 zero digits", 1'b0);
    t_single(32'h99999999, 32'h99999999, "R8 all nines", 1'b0);
    chk("R8 all nines literal", product, 64'h9999999800000001);
    t_single(32'h31415926, 32'h27182818, "R5 busy junk", 1'b1);
    t_back_to_back(32'h99999999, 32'h12345678, 32'h00500005, 32'h90000009);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule